// File: doc/BRIEF.md
# Level and Message Interrupt Router

This block sits beside an I/O bridge and turns two kinds of interrupt source into delivery messages for processors. It watches 128 level-sensitive interrupt lines and accepts message-signalled interrupt writes, each carrying a 9-bit data value. Each level line has its own control register, and each group of 32 message data values shares one control register. Every control register holds an enable bit and the 9-bit ID of the processor that should receive the interrupt.

When a source is pending and enabled, the block offers one delivery per cycle on a valid/ready channel. The delivery carries the target processor ID and a packed vector. The vector merges both source kinds into one number space and includes the ID of the I/O node that raised the interrupt. A fixed-priority scan chooses among competing sources. A level source is sent once per assertion, and a message stays pending until its delivery is accepted.

Top module: `irq_router`

## Requirements
- R1: A level source n is delivered with vector bits 15:0 equal to 0x0800 + (n << 4), so bits 3:0 are zero.
- R2: A message with data value d is delivered with vector bits 15:0 equal to 0x1000 + (d << 4), from 0x1000 for d = 0 up to 0x2FF0 for d = 0x1FF.
- R3: Vector bits 19:16 carry `node_id`, and vector bits 15:14 are zero.
- R4: Control bit 24 is the enable bit. A pending source whose enable bit is 0 is never offered.
- R5: Control bits 22:14 hold the target ID, and `dlv_target` equals that field of the register governing the offered source.
- R6: Only level sources 0 to 0x5F, 0x74 and 0x75 are implemented. Any other level index never produces a delivery, whatever its line or register holds.
- R7: Register addresses 0x00 to 0x7F are the level controls (the address is the line index). Addresses 0x80 to 0x8F are the message controls, and message data d is governed by address 0x80 + (d >> 5).
- R8: After reset every register reads 0 and nothing is offered. Writing only a target ID leaves the source disabled.
- R9: After a level delivery is accepted, that source is offered again only once its line has been low, or its enable bit has been 0, for at least one cycle and it is pending again.
- R10: A message stays pending, even while it is disabled, until its delivery is accepted. The pending bit is then cleared.
- R11: When several sources are eligible, a level source wins over a message, and a lower index wins within each kind.
- R12: A read of a control address returns bit 24 and bits 22:14 as last written, with all other bits 0. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | 4 | ID of this I/O node, placed in the vector |
| lvl_in | input | 128 | Level interrupt lines |
| msi_valid | input | 1 | Message interrupt write strobe |
| msi_data | input | 9 | Data value of the message write |
| reg_we | input | 1 | Control register write strobe |
| reg_addr | input | 8 | Control register address (read and write) |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read data (combinational) |
| dlv_valid | output | 1 | A delivery is offered |
| dlv_ready | input | 1 | The delivery is accepted |
| dlv_target | output | 9 | Target processor ID |
| dlv_vector | output | 20 | Packed interrupt vector |

## Verification
Two things can happen to the same source in one cycle. A delivery can be accepted while a new message write for the same data value arrives. A delivery can also be accepted while software rewrites the source's enable bit or the level line drops. The random phase produces these collisions by mixing message writes, register writes, line toggles and ready values every cycle. A reference model in the bench updates the pending and re-arm state in the order the requirements define, so a message arriving in the accept cycle must stay pending, and the offer in every following cycle is compared against the model.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NODE_W   = 4,
  parameter int LVL_N    = 128,
  parameter int MSI_REGS = 16,
  parameter int MSI_PER  = 32,
  parameter int IMPL_LOW = 96,
  parameter int EXTRA_A  = 116,
  parameter int EXTRA_B  = 117
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NODE_W-1:0]    node_id,
  input  logic [LVL_N-1:0]     lvl_in,
  input  logic                 msi_valid,
  input  logic [8:0]           msi_data,
  input  logic                 reg_we,
  input  logic [7:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 dlv_valid,
  input  logic                 dlv_ready,
  output logic [8:0]           dlv_target,
  output logic [16+NODE_W-1:0] dlv_vector
);
  localparam int MSI_N = MSI_REGS * MSI_PER;
  localparam int GRP_SH = $clog2(MSI_PER);

  function automatic logic [LVL_N-1:0] impl_mask();
    logic [LVL_N-1:0] m;
    for (int i = 0; i < LVL_N; i++) m[i] = (i < IMPL_LOW) || (i == EXTRA_A) || (i == EXTRA_B);
    return m;
  endfunction
  localparam logic [LVL_N-1:0] IMPL = impl_mask();

  logic [LVL_N-1:0]    lvl_en, lvl_arm, lvl_req, lvl_clr;
  logic [8:0]          lvl_tgt [LVL_N];
  logic [MSI_REGS-1:0] msi_en;
  logic [8:0]          msi_tgt [MSI_REGS];
  logic [MSI_N-1:0]    msi_pend, msi_req, msi_clr, msi_set;
  logic                sel_lvl;
  logic [8:0]          sel_idx;
  logic                accept;
  logic                unused_bits;

  wire wr_lvl = reg_we && !reg_addr[7];
  wire wr_msi = reg_we && reg_addr[7] && reg_addr[6:4] == 3'd0;
  assign unused_bits = ^{reg_wdata[31:25], reg_wdata[23], reg_wdata[13:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_en <= '0;
      msi_en <= '0;
      for (int i = 0; i < LVL_N; i++) lvl_tgt[i] <= '0;
      for (int i = 0; i < MSI_REGS; i++) msi_tgt[i] <= '0;
    end else if (wr_lvl) begin
      lvl_en[reg_addr[6:0]]  <= reg_wdata[24];
      lvl_tgt[reg_addr[6:0]] <= reg_wdata[22:14];
    end else if (wr_msi) begin
      msi_en[reg_addr[3:0]]  <= reg_wdata[24];
      msi_tgt[reg_addr[3:0]] <= reg_wdata[22:14];
    end

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr[7]) begin
      reg_rdata[24]    = lvl_en[reg_addr[6:0]];
      reg_rdata[22:14] = lvl_tgt[reg_addr[6:0]];
    end else if (reg_addr[6:4] == 3'd0) begin
      reg_rdata[24]    = msi_en[reg_addr[3:0]];
      reg_rdata[22:14] = msi_tgt[reg_addr[3:0]];
    end
  end

  assign lvl_req = lvl_in & lvl_arm & lvl_en & IMPL;
  always_comb
    for (int j = 0; j < MSI_N; j++) msi_req[j] = msi_pend[j] & msi_en[j >> GRP_SH];

  always_comb begin
    dlv_valid = 1'b0;
    sel_lvl   = 1'b0;
    sel_idx   = '0;
    for (int i = 0; i < LVL_N; i++)
      if (!dlv_valid && lvl_req[i]) begin
        dlv_valid = 1'b1;
        sel_lvl   = 1'b1;
        sel_idx   = 9'(i);
      end
    for (int j = 0; j < MSI_N; j++)
      if (!dlv_valid && msi_req[j]) begin
        dlv_valid = 1'b1;
        sel_idx   = 9'(j);
      end
  end

  assign accept     = dlv_valid && dlv_ready;
  assign dlv_target = sel_lvl ? lvl_tgt[sel_idx[6:0]] : msi_tgt[sel_idx[8:5]];
  assign dlv_vector = {node_id, sel_lvl ? (16'h0800 | {5'b0, sel_idx[6:0], 4'b0})
                                        : (16'h1000 + {3'b0, sel_idx, 4'b0})};

  assign lvl_clr = (accept && sel_lvl) ? (LVL_N'(1) << sel_idx[6:0]) : '0;
  assign msi_clr = (accept && !sel_lvl) ? (MSI_N'(1) << sel_idx) : '0;
  assign msi_set = msi_valid ? (MSI_N'(1) << msi_data) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_arm  <= '1;
      msi_pend <= '0;
    end else begin
      lvl_arm  <= (lvl_arm | ~lvl_in | ~lvl_en) & ~lvl_clr;
      msi_pend <= (msi_pend & ~msi_clr) | msi_set;
    end

  p_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (sel_lvl ? lvl_en[sel_idx[6:0]] : msi_en[sel_idx[8:5]]));
  p_unimpl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && sel_lvl) |-> IMPL[sel_idx[6:0]]);
  p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sel_lvl) |=> !lvl_arm[$past(sel_idx[6:0])]);
  p_msi_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sel_lvl && !(msi_valid && msi_data == sel_idx)) |=> !msi_pend[$past(sel_idx)]);
  p_msi_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_pend[0] && !(accept && !sel_lvl && sel_idx == 9'd0)) |=> msi_pend[0]);
  p_level_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !sel_lvl) |-> lvl_req == '0);
endmodule

// File: tb/test_irq_router.sv
`timescale 1ns/100ps
module test_irq_router;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n;
  logic [3:0]   node_id;
  logic [127:0] lvl_in;
  logic         msi_valid;
  logic [8:0]   msi_data;
  logic         reg_we;
  logic [7:0]   reg_addr;
  logic [31:0]  reg_wdata, reg_rdata;
  logic         dlv_valid, dlv_ready;
  logic [8:0]   dlv_target;
  logic [19:0]  dlv_vector;

  irq_router i_irq_router (.clk, .rst_n, .node_id, .lvl_in, .msi_valid, .msi_data,
    .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .dlv_valid, .dlv_ready,
    .dlv_target, .dlv_vector);

  int checks = 0, errors = 0;
  logic       m_en [144];
  logic [8:0] m_tgt [144];
  logic       m_arm [128];
  logic       m_pend [512];
  logic       e_valid, e_lvl;
  int         e_idx;
  logic [8:0] e_tgt;
  logic [19:0] e_vec;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit impl(int n);
    return n < 96 || n == 116 || n == 117;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] r = '0;
    if (a < 8'd144) begin
      r[24] = m_en[a];
      r[22:14] = m_tgt[a];
    end
    return r;
  endfunction

  task automatic calc();
    e_valid = 0; e_lvl = 0; e_idx = 0;
    for (int i = 0; i < 128; i++)
      if (!e_valid && lvl_in[i] && m_arm[i] && m_en[i] && impl(i)) begin
        e_valid = 1; e_lvl = 1; e_idx = i;
      end
    for (int j = 0; j < 512; j++)
      if (!e_valid && m_pend[j] && m_en[128 + j / 32]) begin
        e_valid = 1; e_idx = j;
      end
    e_tgt = e_lvl ? m_tgt[e_idx] : m_tgt[128 + e_idx / 32];
    e_vec = {node_id, e_lvl ? 16'(32'h800 + e_idx * 16) : 16'(32'h1000 + e_idx * 16)};
  endtask

  task automatic step(string req, bit lit = 0, bit lit_valid = 0, logic [19:0] lit_vec = '0);
    bit acc;
    #1;
    calc();
    chk(dlv_valid === e_valid, req, "valid", 32'(dlv_valid), 32'(e_valid));
    if (e_valid && dlv_valid) begin
      chk(dlv_target === e_tgt, "R5", "target", 32'(dlv_target), 32'(e_tgt));
      chk(dlv_vector === e_vec, req, "vector", 32'(dlv_vector), 32'(e_vec));
    end
    if (lit) begin
      chk(dlv_valid === lit_valid, req, "directed valid", 32'(dlv_valid), 32'(lit_valid));
      if (lit_valid) chk(dlv_vector === lit_vec, req, "directed vector", 32'(dlv_vector), 32'(lit_vec));
    end
    chk(reg_rdata === m_read(reg_addr), "R12", "readback", reg_rdata, m_read(reg_addr));
    @(posedge clk);
    acc = e_valid && dlv_ready;
    for (int i = 0; i < 128; i++)
      m_arm[i] = (acc && e_lvl && e_idx == i) ? 1'b0 : (m_arm[i] | !lvl_in[i] | !m_en[i]);
    if (acc && !e_lvl) m_pend[e_idx] = 1'b0;
    if (msi_valid) m_pend[msi_data] = 1'b1;
    if (reg_we && reg_addr < 8'd144) begin
      m_en[reg_addr] = reg_wdata[24];
      m_tgt[reg_addr] = reg_wdata[22:14];
    end
    @(negedge clk);
    reg_we = 0;
    msi_valid = 0;
  endtask

  task automatic wr(logic [7:0] a, bit en, logic [8:0] tgt);
    reg_we = 1; reg_addr = a;
    reg_wdata = (32'(en) << 24) | (32'(tgt) << 14) | 32'h0000_3A5F;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7731));
    rst_n = 0; node_id = 4'hA; lvl_in = '0; msi_valid = 0; msi_data = '0;
    reg_we = 0; reg_addr = '0; reg_wdata = '0; dlv_ready = 1;
    for (int i = 0; i < 144; i++) begin m_en[i] = 0; m_tgt[i] = '0; end
    for (int i = 0; i < 128; i++) m_arm[i] = 1;
    for (int j = 0; j < 512; j++) m_pend[j] = 0;
    @(negedge clk); @(negedge clk);
    foreach (reg_addr[k]) ;
    reg_addr = 8'h75; #1 chk(reg_rdata === 0, "R8", "reset read lvl", reg_rdata, 0);
    reg_addr = 8'h8F; #1 chk(reg_rdata === 0, "R8", "reset read msi", reg_rdata, 0);
    chk(dlv_valid === 0, "R8", "reset valid", 32'(dlv_valid), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    wr(8'h75, 0, 9'd3); step("R8");
    lvl_in[8'h75] = 1; reg_addr = 8'h75; step("R8", 1, 0);
    wr(8'h75, 1, 9'd5); step("R4");
    dlv_ready = 0; step("R1", 1, 1, 20'hA0F50);
    step("R3", 1, 1, 20'hA0F50);
    dlv_ready = 1; step("R9", 1, 1, 20'hA0F50);
    step("R9", 1, 0); step("R9", 1, 0);
    lvl_in[8'h75] = 0; step("R9", 1, 0);
    lvl_in[8'h75] = 1; step("R9", 1, 1, 20'hA0F50);
    wr(8'h60, 1, 9'd1); lvl_in[8'h60] = 1; step("R6");
    wr(8'h7F, 1, 9'd1); lvl_in[8'h7F] = 1; step("R6", 1, 0);
    step("R6", 1, 0);
    wr(8'h8F, 1, 9'h1AB); step("R7");
    msi_valid = 1; msi_data = 9'h1FF; reg_addr = 8'h8F; step("R10");
    dlv_ready = 0; step("R2", 1, 1, 20'hA2FF0);
    dlv_ready = 1; step("R2", 1, 1, 20'hA2FF0);
    step("R10", 1, 0);
    msi_valid = 1; msi_data = 9'h020; step("R10");
    step("R7", 1, 0); step("R10", 1, 0);
    wr(8'h81, 1, 9'd9); step("R7");
    step("R7", 1, 1, 20'hA1200);
    step("R10", 1, 0);
    wr(8'h03, 1, 9'd2); msi_valid = 1; msi_data = 9'h1E0; step("R11");
    lvl_in[3] = 1; dlv_ready = 0; step("R11", 1, 1, 20'hA0830);
    dlv_ready = 1; step("R11", 1, 1, 20'hA0830);
    step("R11", 1, 1, 20'hA2E00);
    step("R10", 1, 0);
    msi_valid = 1; msi_data = 9'h1FF; step("R10");
    dlv_ready = 1; msi_valid = 1; msi_data = 9'h1FF; step("R10", 1, 1, 20'hA2FF0);
    step("R10", 1, 1, 20'hA2FF0);
    step("R10", 1, 0);

    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 1) == 0) begin
        int n = $urandom_range(0, 3) == 0 ? $urandom_range(0, 127) : $urandom_range(0, 15);
        lvl_in[n] = ~lvl_in[n];
      end
      if ($urandom_range(0, 3) == 0) begin
        msi_valid = 1; msi_data = 9'($urandom_range(0, 511));
      end
      if ($urandom_range(0, 5) == 0) begin
        int k = $urandom_range(0, 3) == 0 ? $urandom_range(0, 143) : 128 + $urandom_range(0, 15);
        if ($urandom_range(0, 1) == 0) k = $urandom_range(0, 15);
        wr(8'(k), $urandom_range(0, 3) != 0, 9'($urandom_range(0, 511)));
      end else
        reg_addr = 8'($urandom_range(0, 255));
      dlv_ready = $urandom_range(0, 3) != 0;
      step("R11");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule